// File: doc/BRIEF.md
# Branch Resolution Unit with Loop Counter

This block settles branch outcomes for a simple in-order 32-bit front end. It owns three special registers: a link register, a loop count register and a 32-bit condition register, which is organised as eight 4-bit fields. Each cycle the front end may present one decoded branch. The branch carries its kind, its own address, a word displacement, a condition-bit select, the bit value that means "taken", a decrement flag, a link flag, a static prediction hint and, for register-indirect branches, the source register. The target is formed by an adder inside the unit. The general-purpose register file is never read.

Unconditional, loop-counter and register-indirect branches resolve in the cycle they are presented. The correct next fetch address appears on the same cycle's result outputs, so these branches add no delay. A condition-dependent branch is checked against its static hint. If the outcome differs, a one-cycle redirect carrying the correct fetch address follows on the next cycle. The redirect also says whether the retained fall-through instructions can be reused. Compare units mark a condition field as pending when they issue and write it when they finish. A branch that tests a pending field is accepted on its hint and parked. It is evaluated once the field is valid, and it redirects only if the hint was wrong.

The controller has three states. READY accepts branches. HELD parks a branch whose condition field is pending. REDIR drives the redirect pulse. The transitions are: park (READY to HELD, a conditional branch on a pending field), mispredict (READY to REDIR, a resolved conditional outcome differs from the hint), late-hit (HELD to READY, the field becomes valid and the outcome matches), late-miss (HELD to REDIR, the field becomes valid and the outcome differs) and flush-done (REDIR to READY, always after one cycle). All other cases stay in the current state.

Top module: `brx_unit`

## Requirements
- R1: After reset the count, link and condition registers are zero, no field is pending, redirect and result-valid are low, redirect_pc is zero and br_ready is high.
- R2: A branch of kind 0 (always) is taken in the cycle it is presented. res_valid is high that cycle, and res_pc is br_pc plus the sign-extended displacement shifted left by 2.
- R3: A branch of kind 1 (loop) decrements the count register by one, with wrap from 0 to all ones. In the same cycle it reports taken exactly when the decremented value is non-zero. When it is not taken, res_pc is br_pc + 4.
- R4: A branch of kind 3 (indirect) is always taken. Its target is the link register (br_ind_ctr = 0) or the count register (br_ind_ctr = 1), with the two low bits cleared. The value used is the one held before the same branch's own link update.
- R5: An accepted branch with br_link set loads the link register with br_pc + 4 on the next cycle. lr_ld / ctr_ld load the registers directly and win over a branch update in the same cycle.
- R6: Condition field f occupies cr_q bits [4f+3:4f]. br_sel[4:2] picks the field and br_sel[1:0] the bit within it. A compare write stores a field and clears its pending flag. A compare issue sets the flag, and wins when both hit the same field in one cycle. Both take effect from the next cycle.
- R7: A branch of kind 2 (conditional) on a non-pending field is taken when the selected bit equals br_want and, if br_dec is set, the decremented count (which is also written back) is non-zero. If the outcome equals br_hint, no redirect follows. Otherwise redirect rises on the next cycle.
- R8: redirect lasts exactly one cycle. redirect_pc is the target if the branch was taken and br_pc + 4 otherwise. redirect_reuse is high only when the hint said taken and the branch was not taken.
- R9: A conditional branch on a pending field is accepted, and br_ready stays low until the field is valid. In the first cycle the field reads valid, res_valid pulses with the outcome. The unit then returns to READY, or redirects on the following cycle if the outcome differs from the hint.
- R10: While redirect is high, br_ready is low. A presented branch is then ignored: it gives no result and changes neither the count nor the link register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A decoded branch is presented |
| br_kind | input | 2 | 0 always, 1 loop, 2 conditional, 3 indirect |
| br_pc | input | 32 | Address of the branch |
| br_disp | input | 24 | Signed word displacement |
| br_sel | input | 5 | Condition bit select (field, bit) |
| br_want | input | 1 | Bit value that makes the condition true |
| br_dec | input | 1 | Conditional branch also decrements and tests the count |
| br_link | input | 1 | Save br_pc + 4 into the link register |
| br_hint | input | 1 | Static prediction, 1 = taken |
| br_ind_ctr | input | 1 | Indirect source: 0 link, 1 count |
| br_ready | output | 1 | Unit can accept a branch this cycle |
| res_valid | output | 1 | A branch outcome is reported this cycle |
| res_taken | output | 1 | Reported outcome |
| res_pc | output | 32 | Correct next fetch address for the reported branch |
| redirect | output | 1 | Flush younger instructions and refetch |
| redirect_pc | output | 32 | Refetch address |
| redirect_reuse | output | 1 | Retained fall-through instructions are valid |
| cmp_issue | input | 1 | A compare claims a condition field |
| cmp_issue_fld | input | 3 | Field claimed |
| cmp_wr | input | 1 | A compare result is written |
| cmp_wr_fld | input | 3 | Field written |
| cmp_wr_data | input | 4 | Field value |
| ctr_ld | input | 1 | Direct load of the count register |
| ctr_ld_data | input | 32 | Count load value |
| lr_ld | input | 1 | Direct load of the link register |
| lr_ld_data | input | 32 | Link load value |
| ctr_q | output | 32 | Count register |
| lr_q | output | 32 | Link register |
| cr_q | output | 32 | Condition register |
| cr_pend | output | 8 | Per-field pending flags |

## Verification
A behavioural reference model predicts every output each cycle. The loop branch is driven with counts of 3, 2, 1 and 0, which separates the taken, exit and wrap cases. Conditional branches are run with each combination of bit value and hint, which tells silent hits apart from redirects that reuse the fall-through path and from redirects to the target. Pending-field cases, both late-hit and late-miss, show whether the parked branch waits for the registered field and whether it redirects only on a wrong hint. A branch presented during a redirect and a link-plus-indirect branch expose ordering faults in the count and link updates.

// File: rtl/brx_pkg.sv
package brx_pkg;

    typedef enum logic [1:0] {
        BK_ALWAYS   = 2'd0,
        BK_LOOP     = 2'd1,
        BK_COND     = 2'd2,
        BK_INDIRECT = 2'd3
    } br_kind_e;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_HELD  = 2'd1,
        ST_REDIR = 2'd2
    } brx_state_e;

endpackage

// File: rtl/brx_cr_file.sv
module brx_cr_file #(
    parameter  int NFLD  = 8,
    parameter  int FW    = 4,
    localparam int FLD_W = $clog2(NFLD),
    localparam int CR_W  = NFLD * FW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [FLD_W-1:0] issue_fld,
    input  logic             wr,
    input  logic [FLD_W-1:0] wr_fld,
    input  logic [FW-1:0]    wr_data,
    output logic [CR_W-1:0]  cr_q,
    output logic [NFLD-1:0]  pend_q
);

    for (genvar f = 0; f < NFLD; f++) begin : g_fld
        logic [FW-1:0] val_q;
        logic          busy_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q  <= '0;
                busy_q <= 1'b0;
            end else begin
                if (wr && (wr_fld == FLD_W'(f))) begin
                    val_q  <= wr_data;
                    busy_q <= 1'b0;
                end
                if (issue && (issue_fld == FLD_W'(f))) begin
                    busy_q <= 1'b1;
                end
            end
        end

        assign cr_q[f*FW +: FW] = val_q;
        assign pend_q[f]        = busy_q;
    end

    // R6: an issued field is pending on the next cycle
    p_issue_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> pend_q[$past(issue_fld)]);

    // R6: a written field (not re-issued) is valid and holds the data
    p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !(issue && (issue_fld == wr_fld)))
        |=> (!pend_q[$past(wr_fld)] && (cr_q[$past(wr_fld)*FW +: FW] == $past(wr_data))));

endmodule

// File: rtl/brx_count_link.sv
module brx_count_link #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctr_ld,
    input  logic [AW-1:0] ctr_ld_data,
    input  logic          lr_ld,
    input  logic [AW-1:0] lr_ld_data,
    input  logic          dec_en,
    input  logic          link_en,
    input  logic [AW-1:0] link_val,
    output logic [AW-1:0] ctr_q,
    output logic [AW-1:0] lr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else if (ctr_ld) begin
            ctr_q <= ctr_ld_data;
        end else if (dec_en) begin
            ctr_q <= ctr_q - AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lr_q <= '0;
        end else if (lr_ld) begin
            lr_q <= lr_ld_data;
        end else if (link_en) begin
            lr_q <= link_val;
        end
    end

    // R3: a decrementing branch lowers the count by exactly one
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !ctr_ld) |=> (ctr_q == $past(ctr_q) - AW'(1)));

    // R5: a linking branch saves its return address
    p_link_save_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && !lr_ld) |=> (lr_q == $past(link_val)));

endmodule

// File: rtl/brx_eval.sv
module brx_eval
    import brx_pkg::*;
#(
    parameter  int AW    = 32,
    parameter  int DW    = 24,
    parameter  int NFLD  = 8,
    parameter  int FW    = 4,
    localparam int CR_W  = NFLD * FW,
    localparam int SEL_W = $clog2(CR_W),
    localparam int BIT_W = $clog2(FW),
    localparam int SX_W  = AW - DW - 2
) (
    input  br_kind_e         kind,
    input  logic [AW-1:0]    pc,
    input  logic [DW-1:0]    disp,
    input  logic [SEL_W-1:0] sel,
    input  logic             want,
    input  logic             dec,
    input  logic             ind_ctr,
    input  logic [AW-1:0]    ctr_q,
    input  logic [AW-1:0]    lr_q,
    input  logic [CR_W-1:0]  cr_q,
    input  logic [NFLD-1:0]  pend_q,
    output logic             taken,
    output logic [AW-1:0]    target,
    output logic [AW-1:0]    seq_pc,
    output logic             is_cond,
    output logic             fld_pending,
    output logic             ctr_ok,
    output logic             dec_req
);

    logic [AW-1:0] rel_tgt;
    logic [AW-1:0] ind_src;
    logic [AW-1:0] ctr_next;
    logic          ctr_live;
    logic          cond_hit;

    assign rel_tgt     = pc + {{SX_W{disp[DW-1]}}, disp, 2'b00};
    assign ind_src     = ind_ctr ? ctr_q : lr_q;
    assign seq_pc      = pc + AW'(4);
    assign ctr_next    = ctr_q - AW'(1);
    assign ctr_live    = (ctr_next != '0);
    assign cond_hit    = (cr_q[sel] == want);
    assign fld_pending = pend_q[sel[SEL_W-1:BIT_W]];
    assign is_cond     = (kind == BK_COND);
    assign ctr_ok      = !dec || ctr_live;
    assign dec_req     = (kind == BK_LOOP) || ((kind == BK_COND) && dec);

    always_comb begin
        unique case (kind)
            BK_ALWAYS: begin
                taken  = 1'b1;
                target = rel_tgt;
            end
            BK_LOOP: begin
                taken  = ctr_live;
                target = rel_tgt;
            end
            BK_COND: begin
                taken  = cond_hit && ctr_ok;
                target = rel_tgt;
            end
            BK_INDIRECT: begin
                taken  = 1'b1;
                target = {ind_src[AW-1:2], 2'b00};
            end
            default: begin
                taken  = 1'b0;
                target = seq_pc;
            end
        endcase
    end

endmodule

// File: rtl/brx_ctrl.sv
module brx_ctrl
    import brx_pkg::*;
#(
    parameter  int AW    = 32,
    parameter  int NFLD  = 8,
    parameter  int FW    = 4,
    localparam int CR_W  = NFLD * FW,
    localparam int SEL_W = $clog2(CR_W),
    localparam int BIT_W = $clog2(FW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic             br_hint,
    input  logic             br_want,
    input  logic [SEL_W-1:0] br_sel,
    input  logic             is_cond,
    input  logic             fld_pending,
    input  logic             taken,
    input  logic             ctr_ok,
    input  logic [AW-1:0]    target,
    input  logic [AW-1:0]    seq_pc,
    input  logic [CR_W-1:0]  cr_q,
    input  logic [NFLD-1:0]  pend_q,
    output logic             br_ready,
    output logic             accept,
    output logic             res_valid,
    output logic             res_taken,
    output logic [AW-1:0]    res_pc,
    output logic             redirect,
    output logic [AW-1:0]    redirect_pc,
    output logic             redirect_reuse
);

    brx_state_e state_q, state_d;

    // parked conditional branch
    logic [SEL_W-1:0] h_sel_q;
    logic             h_want_q, h_hint_q, h_cok_q;
    logic [AW-1:0]    h_tgt_q, h_seq_q;
    logic             h_pend, h_taken;

    // redirect capture
    logic             park;
    logic             go_redir;
    logic [AW-1:0]    rpc_d, rpc_q;
    logic             reuse_d, reuse_q;

    assign h_pend  = pend_q[h_sel_q[SEL_W-1:BIT_W]];
    assign h_taken = h_cok_q && (cr_q[h_sel_q] == h_want_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d  = state_q;
        park     = 1'b0;
        go_redir = 1'b0;
        rpc_d    = rpc_q;
        reuse_d  = reuse_q;
        unique case (state_q)
            ST_READY: begin
                if (br_valid && is_cond) begin
                    if (fld_pending) begin
                        state_d = ST_HELD;           // park
                        park    = 1'b1;
                    end else if (taken != br_hint) begin
                        state_d  = ST_REDIR;         // mispredict
                        go_redir = 1'b1;
                        rpc_d    = taken ? target : seq_pc;
                        reuse_d  = br_hint && !taken;
                    end
                end
            end
            ST_HELD: begin
                if (!h_pend) begin
                    if (h_taken != h_hint_q) begin
                        state_d  = ST_REDIR;         // late-miss
                        go_redir = 1'b1;
                        rpc_d    = h_taken ? h_tgt_q : h_seq_q;
                        reuse_d  = h_hint_q && !h_taken;
                    end else begin
                        state_d = ST_READY;          // late-hit
                    end
                end
            end
            ST_REDIR: begin
                state_d = ST_READY;                  // flush-done
            end
            default: begin
                state_d = ST_READY;
            end
        endcase
    end

    // data registers for the parked branch and the redirect
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_sel_q  <= '0;
            h_want_q <= 1'b0;
            h_hint_q <= 1'b0;
            h_cok_q  <= 1'b0;
            h_tgt_q  <= '0;
            h_seq_q  <= '0;
            rpc_q    <= '0;
            reuse_q  <= 1'b0;
        end else begin
            if (park) begin
                h_sel_q  <= br_sel;
                h_want_q <= br_want;
                h_hint_q <= br_hint;
                h_cok_q  <= ctr_ok;
                h_tgt_q  <= target;
                h_seq_q  <= seq_pc;
            end
            if (go_redir) begin
                rpc_q   <= rpc_d;
                reuse_q <= reuse_d;
            end
        end
    end

    // outputs
    always_comb begin
        br_ready       = 1'b0;
        res_valid      = 1'b0;
        res_taken      = 1'b0;
        res_pc         = '0;
        redirect       = 1'b0;
        redirect_pc    = rpc_q;
        redirect_reuse = reuse_q;
        unique case (state_q)
            ST_READY: begin
                br_ready = 1'b1;
                if (br_valid && !(is_cond && fld_pending)) begin
                    res_valid = 1'b1;
                    res_taken = taken;
                    res_pc    = taken ? target : seq_pc;
                end
            end
            ST_HELD: begin
                if (!h_pend) begin
                    res_valid = 1'b1;
                    res_taken = h_taken;
                    res_pc    = h_taken ? h_tgt_q : h_seq_q;
                end
            end
            ST_REDIR: begin
                redirect = 1'b1;
            end
            default: begin
                br_ready = 1'b0;
            end
        endcase
    end

    assign accept = br_ready && br_valid;

    // R7: a resolved conditional outcome that differs from the hint redirects next cycle
    p_miss_redirects_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (br_ready && br_valid && is_cond && !fld_pending && (taken != br_hint)) |=> redirect);

    // R7: a resolved conditional outcome matching the hint never redirects
    p_hit_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (br_ready && br_valid && is_cond && !fld_pending && (taken == br_hint)) |=> !redirect);

    // R8: redirect is a single-cycle pulse
    p_redirect_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect);

    // R9: a parked branch whose hint holds returns to accepting branches
    p_late_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_HELD) && !h_pend && (h_taken == h_hint_q)) |=> (br_ready && !redirect));

    // R9: a parked branch stays parked while its field is pending
    p_park_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_HELD) && h_pend) |=> (!br_ready && !redirect));

endmodule

// File: rtl/brx_unit.sv
module brx_unit
    import brx_pkg::*;
#(
    parameter  int AW    = 32,
    parameter  int DW    = 24,
    parameter  int NFLD  = 8,
    parameter  int FW    = 4,
    localparam int CR_W  = NFLD * FW,
    localparam int SEL_W = $clog2(CR_W),
    localparam int FLD_W = $clog2(NFLD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic [1:0]       br_kind,
    input  logic [AW-1:0]    br_pc,
    input  logic [DW-1:0]    br_disp,
    input  logic [SEL_W-1:0] br_sel,
    input  logic             br_want,
    input  logic             br_dec,
    input  logic             br_link,
    input  logic             br_hint,
    input  logic             br_ind_ctr,
    output logic             br_ready,
    output logic             res_valid,
    output logic             res_taken,
    output logic [AW-1:0]    res_pc,
    output logic             redirect,
    output logic [AW-1:0]    redirect_pc,
    output logic             redirect_reuse,
    input  logic             cmp_issue,
    input  logic [FLD_W-1:0] cmp_issue_fld,
    input  logic             cmp_wr,
    input  logic [FLD_W-1:0] cmp_wr_fld,
    input  logic [FW-1:0]    cmp_wr_data,
    input  logic             ctr_ld,
    input  logic [AW-1:0]    ctr_ld_data,
    input  logic             lr_ld,
    input  logic [AW-1:0]    lr_ld_data,
    output logic [AW-1:0]    ctr_q,
    output logic [AW-1:0]    lr_q,
    output logic [CR_W-1:0]  cr_q,
    output logic [NFLD-1:0]  cr_pend
);

    br_kind_e      kind;
    logic          taken, is_cond, fld_pending, ctr_ok, dec_req;
    logic [AW-1:0] target, seq_pc;
    logic          accept;
    logic          dec_en, link_en;

    assign kind = br_kind_e'(br_kind);

    brx_cr_file #(.NFLD(NFLD), .FW(FW)) u_cr (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (cmp_issue),
        .issue_fld (cmp_issue_fld),
        .wr        (cmp_wr),
        .wr_fld    (cmp_wr_fld),
        .wr_data   (cmp_wr_data),
        .cr_q      (cr_q),
        .pend_q    (cr_pend)
    );

    brx_eval #(.AW(AW), .DW(DW), .NFLD(NFLD), .FW(FW)) u_eval (
        .kind        (kind),
        .pc          (br_pc),
        .disp        (br_disp),
        .sel         (br_sel),
        .want        (br_want),
        .dec         (br_dec),
        .ind_ctr     (br_ind_ctr),
        .ctr_q       (ctr_q),
        .lr_q        (lr_q),
        .cr_q        (cr_q),
        .pend_q      (cr_pend),
        .taken       (taken),
        .target      (target),
        .seq_pc      (seq_pc),
        .is_cond     (is_cond),
        .fld_pending (fld_pending),
        .ctr_ok      (ctr_ok),
        .dec_req     (dec_req)
    );

    brx_ctrl #(.AW(AW), .NFLD(NFLD), .FW(FW)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .br_valid       (br_valid),
        .br_hint        (br_hint),
        .br_want        (br_want),
        .br_sel         (br_sel),
        .is_cond        (is_cond),
        .fld_pending    (fld_pending),
        .taken          (taken),
        .ctr_ok         (ctr_ok),
        .target         (target),
        .seq_pc         (seq_pc),
        .cr_q           (cr_q),
        .pend_q         (cr_pend),
        .br_ready       (br_ready),
        .accept         (accept),
        .res_valid      (res_valid),
        .res_taken      (res_taken),
        .res_pc         (res_pc),
        .redirect       (redirect),
        .redirect_pc    (redirect_pc),
        .redirect_reuse (redirect_reuse)
    );

    assign dec_en  = accept && dec_req;
    assign link_en = accept && br_link;

    brx_count_link #(.AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctr_ld      (ctr_ld),
        .ctr_ld_data (ctr_ld_data),
        .lr_ld       (lr_ld),
        .lr_ld_data  (lr_ld_data),
        .dec_en      (dec_en),
        .link_en     (link_en),
        .link_val    (seq_pc),
        .ctr_q       (ctr_q),
        .lr_q        (lr_q)
    );

    // R10: nothing is accepted while a redirect flushes the front end
    p_flush_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (!br_ready && !res_valid && !dec_en && !link_en));

    // R2: an always-taken branch reports a taken result in its own cycle
    p_always_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (br_ready && br_valid && (kind == BK_ALWAYS)) |-> (res_valid && res_taken));

endmodule

// File: tb/test_brx_unit.sv
`timescale 1ns/1ps
module test_brx_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [1:0]  br_kind = 2'd0;
    logic [31:0] br_pc = '0;
    logic [23:0] br_disp = '0;
    logic [4:0]  br_sel = '0;
    logic        br_want = 1'b0, br_dec = 1'b0, br_link = 1'b0, br_hint = 1'b0, br_ind_ctr = 1'b0;
    logic        cmp_issue = 1'b0, cmp_wr = 1'b0;
    logic [2:0]  cmp_issue_fld = '0, cmp_wr_fld = '0;
    logic [3:0]  cmp_wr_data = '0;
    logic        ctr_ld = 1'b0, lr_ld = 1'b0;
    logic [31:0] ctr_ld_data = '0, lr_ld_data = '0;

    logic        br_ready, res_valid, res_taken, redirect, redirect_reuse;
    logic [31:0] res_pc, redirect_pc, ctr_q, lr_q, cr_q;
    logic [7:0]  cr_pend;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    brx_unit i_brx_unit (
        .clk(clk), .rst_n(rst_n),
        .br_valid(br_valid), .br_kind(br_kind), .br_pc(br_pc), .br_disp(br_disp),
        .br_sel(br_sel), .br_want(br_want), .br_dec(br_dec), .br_link(br_link),
        .br_hint(br_hint), .br_ind_ctr(br_ind_ctr),
        .br_ready(br_ready), .res_valid(res_valid), .res_taken(res_taken), .res_pc(res_pc),
        .redirect(redirect), .redirect_pc(redirect_pc), .redirect_reuse(redirect_reuse),
        .cmp_issue(cmp_issue), .cmp_issue_fld(cmp_issue_fld),
        .cmp_wr(cmp_wr), .cmp_wr_fld(cmp_wr_fld), .cmp_wr_data(cmp_wr_data),
        .ctr_ld(ctr_ld), .ctr_ld_data(ctr_ld_data), .lr_ld(lr_ld), .lr_ld_data(lr_ld_data),
        .ctr_q(ctr_q), .lr_q(lr_q), .cr_q(cr_q), .cr_pend(cr_pend)
    );

    // reference model state: 0 ready, 1 parked, 2 redirecting
    int          m_st = 0;
    logic [31:0] m_ctr = '0, m_lr = '0, m_cr = '0, m_rpc = '0;
    logic [7:0]  m_pend = '0;
    logic        m_reuse = 1'b0;
    logic [4:0]  h_sel = '0;
    logic        h_want = 1'b0, h_hint = 1'b0, h_cok = 1'b0;
    logic [31:0] h_tgt = '0, h_seq = '0;

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic clear_inputs();
        br_valid = 0; br_kind = 0; br_pc = 0; br_disp = 0; br_sel = 0; br_want = 0;
        br_dec = 0; br_link = 0; br_hint = 0; br_ind_ctr = 0;
        cmp_issue = 0; cmp_issue_fld = 0; cmp_wr = 0; cmp_wr_fld = 0; cmp_wr_data = 0;
        ctr_ld = 0; ctr_ld_data = 0; lr_ld = 0; lr_ld_data = 0;
    endtask

    // one clock: predict, compare, advance the model
    task automatic tick(input string tag);
        logic        e_ready, e_rv, e_rt, tk, acc, cok;
        logic [31:0] e_rp, tgt, seq, nc;
        int          d, n_st;
        logic [31:0] n_ctr, n_lr, n_cr, n_rpc;
        logic [7:0]  n_pend;
        logic        n_reuse;
        #1;
        e_ready = (m_st == 0);
        e_rv = 0; e_rt = 0; e_rp = 0; acc = 0;
        n_st = m_st; n_ctr = m_ctr; n_lr = m_lr; n_cr = m_cr; n_pend = m_pend;
        n_rpc = m_rpc; n_reuse = m_reuse;
        d   = $signed(br_disp);
        seq = br_pc + 32'd4;
        nc  = m_ctr - 32'd1;
        tk  = 0; tgt = br_pc + 32'(d * 4); cok = 1;
        if (m_st == 0 && br_valid) begin
            acc = 1;
            case (br_kind)
                2'd0: tk = 1;
                2'd1: tk = (nc != 0);
                2'd2: begin
                    cok = !br_dec || (nc != 0);
                    tk  = cok && (m_cr[br_sel] == br_want);
                end
                default: begin
                    tk  = 1;
                    tgt = (br_ind_ctr ? m_ctr : m_lr) & 32'hFFFF_FFFC;
                end
            endcase
            if (br_kind == 2'd2 && m_pend[br_sel / 4]) begin
                n_st = 1; h_sel = br_sel; h_want = br_want; h_hint = br_hint;
                h_cok = cok; h_tgt = tgt; h_seq = seq;
            end else begin
                e_rv = 1; e_rt = tk; e_rp = tk ? tgt : seq;
                if (br_kind == 2'd2 && tk != br_hint) begin
                    n_st = 2; n_rpc = e_rp; n_reuse = br_hint && !tk;
                end
            end
        end else if (m_st == 1) begin
            if (!m_pend[h_sel / 4]) begin
                tk = h_cok && (m_cr[h_sel] == h_want);
                e_rv = 1; e_rt = tk; e_rp = tk ? h_tgt : h_seq;
                if (tk != h_hint) begin
                    n_st = 2; n_rpc = e_rp; n_reuse = h_hint && !tk;
                end else begin
                    n_st = 0;
                end
            end
        end else if (m_st == 2) begin
            n_st = 0;
        end
        if (ctr_ld) n_ctr = ctr_ld_data;
        else if (acc && (br_kind == 2'd1 || (br_kind == 2'd2 && br_dec))) n_ctr = nc;
        if (lr_ld) n_lr = lr_ld_data;
        else if (acc && br_link) n_lr = seq;
        if (cmp_wr) begin
            n_cr[cmp_wr_fld*4 +: 4] = cmp_wr_data;
            n_pend[cmp_wr_fld] = 1'b0;
        end
        if (cmp_issue) n_pend[cmp_issue_fld] = 1'b1;

        check(tag, "br_ready", 32'(br_ready), 32'(e_ready));
        check(tag, "res_valid", 32'(res_valid), 32'(e_rv));
        check(tag, "res_taken", 32'(res_taken), 32'(e_rt));
        check(tag, "res_pc", res_pc, e_rp);
        check(tag, "redirect", 32'(redirect), 32'(m_st == 2));
        check(tag, "redirect_pc", redirect_pc, m_rpc);
        check(tag, "redirect_reuse", 32'(redirect_reuse), 32'(m_reuse));
        check(tag, "ctr_q", ctr_q, m_ctr);
        check(tag, "lr_q", lr_q, m_lr);
        check(tag, "cr_q", cr_q, m_cr);
        check(tag, "cr_pend", 32'(cr_pend), 32'(m_pend));

        @(posedge clk);
        m_st = n_st; m_ctr = n_ctr; m_lr = n_lr; m_cr = n_cr; m_pend = n_pend;
        m_rpc = n_rpc; m_reuse = n_reuse;
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic br(input logic [1:0] k, input logic [31:0] pc, input logic [23:0] disp,
                      input logic [4:0] sel, input logic want, input logic dec,
                      input logic link, input logic hint, input logic ind);
        br_valid = 1; br_kind = k; br_pc = pc; br_disp = disp; br_sel = sel;
        br_want = want; br_dec = dec; br_link = link; br_hint = hint; br_ind_ctr = ind;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick("R1"); tick("R1");

        // R3: loop counter from 3 down through zero and wrap
        ctr_ld = 1; ctr_ld_data = 32'd3; tick("R5");
        br(2'd1, 32'h1000, 24'hFFFFFC, 0, 0, 0, 0, 0, 0); tick("R3");
        br(2'd1, 32'h1000, 24'hFFFFFC, 0, 0, 0, 0, 0, 0); tick("R3");
        br(2'd1, 32'h1000, 24'hFFFFFC, 0, 0, 0, 0, 0, 0); tick("R3");
        br(2'd1, 32'h1000, 24'hFFFFFC, 0, 0, 0, 0, 0, 0); tick("R3");
        tick("R3");

        // R2 / R5: always-taken with link
        br(2'd0, 32'h2000, 24'h000010, 0, 0, 0, 1, 0, 0); tick("R2");
        tick("R5");
        br(2'd0, 32'h2100, 24'h800000, 0, 0, 0, 0, 0, 0); tick("R2");

        // R4: indirect via link, linking in the same branch; then via count
        lr_ld = 1; lr_ld_data = 32'h0040_0003; tick("R5");
        br(2'd3, 32'h3000, 0, 0, 0, 0, 1, 0, 0); tick("R4");
        tick("R4");
        ctr_ld = 1; ctr_ld_data = 32'h0000_5557; tick("R5");
        br(2'd3, 32'h3100, 0, 0, 0, 0, 0, 0, 1); tick("R4");
        // R5: load wins over a linking branch
        br(2'd0, 32'h3200, 24'h4, 0, 0, 0, 1, 0, 0); lr_ld = 1; lr_ld_data = 32'h0000_7770; tick("R5");
        tick("R5");

        // R6: field 2 = 1010
        cmp_wr = 1; cmp_wr_fld = 3'd2; cmp_wr_data = 4'b1010; tick("R6");

        // R7: conditional hits and misses
        br(2'd2, 32'h4000, 24'h20, 5'd9, 1, 0, 0, 1, 0); tick("R7");
        tick("R7");
        br(2'd2, 32'h4000, 24'h20, 5'd9, 1, 0, 0, 0, 0); tick("R7");
        br(2'd0, 32'h4100, 24'h8, 0, 0, 0, 1, 0, 0); tick("R10");   // ignored during redirect
        tick("R10");
        br(2'd2, 32'h4200, 24'h20, 5'd8, 1, 0, 0, 1, 0); tick("R8");
        tick("R8");
        tick("R8");

        // R7: conditional with decrement reaching zero
        ctr_ld = 1; ctr_ld_data = 32'd1; tick("R5");
        br(2'd2, 32'h4300, 24'h10, 5'd9, 1, 1, 0, 1, 0); tick("R7");
        tick("R8");
        ctr_ld = 1; ctr_ld_data = 32'd5; tick("R5");
        br(2'd2, 32'h4400, 24'h10, 5'd11, 1, 1, 0, 0, 0); tick("R7");
        tick("R7");

        // R9: pending field, late hit
        cmp_issue = 1; cmp_issue_fld = 3'd5; tick("R6");
        br(2'd2, 32'h5000, 24'h40, 5'd20, 1, 0, 0, 1, 0); tick("R9");
        br(2'd0, 32'h5100, 24'h4, 0, 0, 0, 1, 0, 0); tick("R9");
        tick("R9");
        cmp_wr = 1; cmp_wr_fld = 3'd5; cmp_wr_data = 4'b0001; tick("R9");
        tick("R9");
        tick("R9");

        // R9: pending field, late miss
        cmp_issue = 1; cmp_issue_fld = 3'd5; tick("R6");
        br(2'd2, 32'h6000, 24'h40, 5'd20, 1, 0, 0, 1, 0); tick("R9");
        cmp_wr = 1; cmp_wr_fld = 3'd5; cmp_wr_data = 4'b0000; tick("R9");
        tick("R9");
        tick("R9");
        tick("R9");

        // R6: issue and write to the same field in one cycle
        cmp_issue = 1; cmp_issue_fld = 3'd3; cmp_wr = 1; cmp_wr_fld = 3'd3; cmp_wr_data = 4'b0110; tick("R6");
        cmp_wr = 1; cmp_wr_fld = 3'd3; cmp_wr_data = 4'b1001; tick("R6");
        tick("R6");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule